// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block maps every 32-bit request address from a processor onto one of eight programmable address windows. Each window holds a control word (enable, target identifier, attribute byte and a size mask) and a base page. Two of the windows also hold a remap page and a 32-bit upper address word, so that they can move a request into another part of a 64-bit address space. Software programs the windows through a single-cycle register write port. Each request is matched against all eight windows in parallel. When more than one window claims the address, the lowest-numbered window wins. The result is returned one clock after the request.

Window sizes are counted in 64 KiB pages. The size field is a mask of ones that starts at bit 0 of the field. A mask of all zeros gives a one-page (64 KiB) window, and a mask of 0x00FF gives a 256-page (16 MiB) window. The mask bits pick which page-number bits take part in the compare and which bits pass through from the request into the translated address. The low 16 address bits never take part in the compare and always pass through unchanged. Software is expected to clear a window's control word before it moves that window, and to set remap-low equal to the base when no translation is wanted.

Top module: `awd_decoder`

## Requirements
- R1: After reset every window is disabled, so a valid request gives `rsp_miss`=1, `rsp_hit`=0, `rsp_win`=0, `rsp_target`=0, `rsp_attr`=0 and `rsp_addr`={32'h0, request address}. While reset is applied, `rsp_valid`, `rsp_hit` and `rsp_miss` are all 0.
- R2: Control word layout: bit 0 is the enable, bits 7:4 are the target, bits 15:8 are the attribute and bits 31:16 are the size mask. Bits 3:1 are ignored. A window whose enable is 0, including one whose control word was written with zero, never produces a hit.
- R3: An enabled window hits when (addr[31:16] & ~size) == (base[31:16] & ~size). A size of 0x0000 covers exactly one 64 KiB page and 0x00FF covers 16 MiB. Bits 15:0 of the address and of the base never affect the match.
- R4: When several windows hit, the lowest-numbered one is reported.
- R5: For a window with remap registers (windows 0 and 1 by default), the translated address is {remap_hi, (remap_lo[31:16] & ~size) | (addr[31:16] & size), addr[15:0]}.
- R6: A remap window whose remap-low equals its base, with remap-high zero, returns the request address unchanged with zero upper bits.
- R7: A window without remap registers returns {32'h0, addr}. Writes to its remap-low or remap-high select are ignored.
- R8: `rsp_valid` follows `req_valid` one clock later. When `rsp_valid`=1, exactly one of `rsp_hit` and `rsp_miss` is set. When `rsp_valid`=0, both are 0.
- R9: A register write takes effect on the clock edge that accepts it. A request accepted on that same edge still sees the old value, and a request on the next edge sees the new one.
- R10: On a hit, `rsp_win`, `rsp_target` and `rsp_attr` carry the winning window's index and its control-word fields.

Write select encoding for `cfg_wr_sel`: 0 selects the control word, 1 the base, 2 remap-low and 3 remap-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_win | input | 3 | Window number being written |
| cfg_wr_sel | input | 2 | Register select: 0 control, 1 base, 2 remap-low, 3 remap-high |
| cfg_wr_data | input | 32 | Write data |
| req_valid | input | 1 | Request address is valid this cycle |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Result valid; the request was accepted on the previous edge |
| rsp_hit | output | 1 | A window matched |
| rsp_miss | output | 1 | No window matched |
| rsp_win | output | 3 | Index of the winning window |
| rsp_target | output | 4 | Target identifier of the winning window |
| rsp_attr | output | 8 | Attribute byte of the winning window |
| rsp_addr | output | 64 | Translated address |

## Verification
A corrupted size mask or base page shows up on the very next response. Depending on which bit is wrong, it appears as a hit where a miss was due, a miss where a hit was due, or wrong pass-through bits in the middle of `rsp_addr`. A broken priority chain or a stale enable appears as a wrong `rsp_win` or `rsp_target` on the first request that overlaps two windows or touches a cleared window. The bench therefore programs overlapping windows, one-page and 16 MiB windows, and a clear that coincides with a request. It checks every field of each response on the cycle after the request was issued.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int ADDR_W  = 32;
  localparam int PAGE_W  = 16;
  localparam int SIZE_W  = ADDR_W - PAGE_W;
  localparam int HI_W    = 32;
  localparam int XLAT_W  = ADDR_W + HI_W;
  localparam int TGT_W   = 4;
  localparam int ATTR_W  = 8;

  // control word field positions
  localparam int EN_BIT   = 0;
  localparam int TGT_LSB  = 4;
  localparam int ATTR_LSB = 8;
  localparam int SIZE_LSB = 16;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BASE = 2'd1,
    SEL_RLO  = 2'd2,
    SEL_RHI  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [SIZE_W-1:0] size;
    logic [ATTR_W-1:0] attr;
    logic [TGT_W-1:0]  tgt;
    logic              en;
  } win_ctrl_t;

  function automatic win_ctrl_t unpack_ctrl(input logic [ADDR_W-1:0] d);
    win_ctrl_t c;
    c.size = d[SIZE_LSB +: SIZE_W];
    c.attr = d[ATTR_LSB +: ATTR_W];
    c.tgt  = d[TGT_LSB +: TGT_W];
    c.en   = d[EN_BIT];
    return c;
  endfunction
endpackage

// File: rtl/awd_win_regs.sv
module awd_win_regs
  import awd_pkg::*;
#(
  parameter bit HAS_REMAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  output win_ctrl_t         ctrl_q,
  output logic [SIZE_W-1:0] base_q,
  output logic [SIZE_W-1:0] rlo_q,
  output logic [HI_W-1:0]   rhi_q
);
  win_ctrl_t         ctrl_d;
  logic [SIZE_W-1:0] base_d;
  logic              ctrl_we;
  logic              base_we;
  logic              unused_low;

  // reserved control bits and low base bits are not stored
  assign unused_low = ^{wr_data[TGT_LSB-1:EN_BIT+1], wr_data[PAGE_W-1:0]};

  always_comb begin
    ctrl_we = wr_hit && (wr_sel == SEL_CTRL);
    base_we = wr_hit && (wr_sel == SEL_BASE);
    ctrl_d  = unpack_ctrl(wr_data);
    base_d  = wr_data[ADDR_W-1:PAGE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_we) begin
      base_q <= base_d;
    end
  end

  generate
    if (HAS_REMAP) begin : g_remap
      logic rlo_we;
      logic rhi_we;
      logic [SIZE_W-1:0] rlo_d;
      logic [HI_W-1:0]   rhi_d;

      always_comb begin
        rlo_we = wr_hit && (wr_sel == SEL_RLO);
        rhi_we = wr_hit && (wr_sel == SEL_RHI);
        rlo_d  = wr_data[ADDR_W-1:PAGE_W];
        rhi_d  = wr_data[HI_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rlo_q <= '0;
        end else if (rlo_we) begin
          rlo_q <= rlo_d;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rhi_q <= '0;
        end else if (rhi_we) begin
          rhi_q <= rhi_d;
        end
      end
    end else begin : g_no_remap
      assign rlo_q = '0;
      assign rhi_q = '0;
    end
  endgenerate

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_sel == SEL_CTRL) |=>
      (ctrl_q.en == $past(wr_data[EN_BIT]) &&
       ctrl_q.size == $past(wr_data[ADDR_W-1:SIZE_LSB]))) // R9
    else $error("control write not applied");
endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
  import awd_pkg::*;
#(
  parameter bit HAS_REMAP = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  win_ctrl_t         ctrl,
  input  logic [SIZE_W-1:0] base_pg,
  input  logic [SIZE_W-1:0] rlo_pg,
  input  logic [HI_W-1:0]   rhi,
  output logic              hit,
  output logic [XLAT_W-1:0] xlat
);
  logic [SIZE_W-1:0] addr_pg;
  logic [SIZE_W-1:0] keep_mask;

  always_comb begin
    addr_pg   = addr[ADDR_W-1:PAGE_W];
    keep_mask = ~ctrl.size;
    hit       = ctrl.en && ((addr_pg & keep_mask) == (base_pg & keep_mask));
  end

  generate
    if (HAS_REMAP) begin : g_xlat
      always_comb begin
        xlat = {rhi, (rlo_pg & keep_mask) | (addr_pg & ctrl.size),
                addr[PAGE_W-1:0]};
      end
    end else begin : g_pass
      logic unused_remap;
      assign unused_remap = ^{rlo_pg, rhi};
      always_comb begin
        xlat = {{HI_W{1'b0}}, addr};
      end
    end
  endgenerate
endmodule

// File: rtl/awd_prio_sel.sv
module awd_prio_sel #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     hits,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = |hits;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
      end
    end
  end

  always_comb begin
    AST_GRANT_ONEHOT: assert ($onehot0(grant)) // R4
      else $error("more than one window granted");
    AST_GRANT_FROM_HIT: assert ((grant & ~hits) == '0) // R4
      else $error("grant without hit");
  end
endmodule

// File: rtl/awd_decoder.sv
module awd_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter logic [NUM_WIN-1:0] REMAP_MAP = 8'b0000_0011,
  localparam int IDX_W = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [IDX_W-1:0]  cfg_wr_win,
  input  logic [1:0]        cfg_wr_sel,
  input  logic [ADDR_W-1:0] cfg_wr_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [IDX_W-1:0]  rsp_win,
  output logic [TGT_W-1:0]  rsp_target,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic [XLAT_W-1:0] rsp_addr
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  win_ctrl_t         ctrl_a [NUM_WIN];
  logic [SIZE_W-1:0] base_a [NUM_WIN];
  logic [SIZE_W-1:0] rlo_a  [NUM_WIN];
  logic [HI_W-1:0]   rhi_a  [NUM_WIN];
  logic [XLAT_W-1:0] xlat_a [NUM_WIN];
  logic [NUM_WIN-1:0] hit_v;
  logic [NUM_WIN-1:0] en_v;
  logic [NUM_WIN-1:0] wr_hit_v;

  generate
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      assign wr_hit_v[i] = cfg_wr_en && (cfg_wr_win == IDX_W'(i));
      assign en_v[i]     = ctrl_a[i].en;

      awd_win_regs #(.HAS_REMAP(REMAP_MAP[i])) i_regs (
        .clk     (clk),
        .rst_n   (rst_core_n),
        .wr_hit  (wr_hit_v[i]),
        .wr_sel  (cfg_wr_sel),
        .wr_data (cfg_wr_data),
        .ctrl_q  (ctrl_a[i]),
        .base_q  (base_a[i]),
        .rlo_q   (rlo_a[i]),
        .rhi_q   (rhi_a[i])
      );

      awd_win_match #(.HAS_REMAP(REMAP_MAP[i])) i_match (
        .addr    (req_addr),
        .ctrl    (ctrl_a[i]),
        .base_pg (base_a[i]),
        .rlo_pg  (rlo_a[i]),
        .rhi     (rhi_a[i]),
        .hit     (hit_v[i]),
        .xlat    (xlat_a[i])
      );
    end
  endgenerate

  logic [NUM_WIN-1:0] grant_v;
  logic [IDX_W-1:0]   win_idx;
  logic               any_hit;

  awd_prio_sel #(.N(NUM_WIN)) i_prio (
    .hits  (hit_v),
    .grant (grant_v),
    .idx   (win_idx),
    .any   (any_hit)
  );

  // select fields of the granted window (one-hot OR mux)
  logic [TGT_W-1:0]  sel_tgt;
  logic [ATTR_W-1:0] sel_attr;
  logic [XLAT_W-1:0] sel_xlat;

  always_comb begin
    sel_tgt  = '0;
    sel_attr = '0;
    sel_xlat = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (grant_v[i]) begin
        sel_tgt  = sel_tgt  | ctrl_a[i].tgt;
        sel_attr = sel_attr | ctrl_a[i].attr;
        sel_xlat = sel_xlat | xlat_a[i];
      end
    end
  end

  // next state of the response stage
  logic              valid_d;
  logic              hit_d;
  logic              miss_d;
  logic              pay_en;
  logic [IDX_W-1:0]  win_d;
  logic [TGT_W-1:0]  tgt_d;
  logic [ATTR_W-1:0] attr_d;
  logic [XLAT_W-1:0] addr_d;

  always_comb begin
    valid_d = req_valid;
    hit_d   = req_valid && any_hit;
    miss_d  = req_valid && !any_hit;
    pay_en  = req_valid;
    win_d   = any_hit ? win_idx  : '0;
    tgt_d   = any_hit ? sel_tgt  : '0;
    attr_d  = any_hit ? sel_attr : '0;
    addr_d  = any_hit ? sel_xlat : {{HI_W{1'b0}}, req_addr};
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
      rsp_hit   <= hit_d;
      rsp_miss  <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rsp_win    <= '0;
      rsp_target <= '0;
      rsp_attr   <= '0;
      rsp_addr   <= '0;
    end else if (pay_en) begin
      rsp_win    <= win_d;
      rsp_target <= tgt_d;
      rsp_attr   <= attr_d;
      rsp_addr   <= addr_d;
    end
  end

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_core_n)
    rsp_valid |-> (rsp_hit ^ rsp_miss)) // R8
    else $error("hit/miss not exclusive");
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_core_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss)) // R8
    else $error("flag without valid");
  AST_REQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_core_n)
    req_valid |=> rsp_valid) // R8
    else $error("response not one cycle after request");
  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_core_n)
    req_valid |=> (rsp_addr[PAGE_W-1:0] == $past(req_addr[PAGE_W-1:0]))) // R5
    else $error("low address bits altered");
  AST_DISABLED_MISS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && en_v == '0) |=> rsp_miss) // R2
    else $error("hit with every window disabled");
endmodule

// File: tb/test_awd_decoder.sv
module test_awd_decoder;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [2:0]  cfg_wr_win;
  logic [1:0]  cfg_wr_sel;
  logic [31:0] cfg_wr_data;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [2:0]  rsp_win;
  logic [3:0]  rsp_target;
  logic [7:0]  rsp_attr;
  logic [63:0] rsp_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  awd_decoder i_awd_decoder (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_win(cfg_wr_win),
    .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_win(rsp_win), .rsp_target(rsp_target), .rsp_attr(rsp_attr),
    .rsp_addr(rsp_addr)
  );

  typedef struct {
    logic        hit;
    logic [2:0]  win;
    logic [3:0]  tgt;
    logic [7:0]  attr;
    logic [63:0] addr;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // shadow of what software wrote
  logic [31:0] sh_ctrl [8];
  logic [31:0] sh_base [8];
  logic [31:0] sh_rlo  [8];
  logic [31:0] sh_rhi  [8];
  localparam logic [7:0] REMAP_WINS = 8'b0000_0011;

  function automatic logic [31:0] mk_ctrl(input logic [15:0] size,
      input logic [7:0] attr, input logic [3:0] tgt);
    return {size, attr, tgt, 3'b000, 1'b1};
  endfunction

  function automatic exp_t predict(input logic [31:0] a, input string tag);
    exp_t e;
    e.hit = 0; e.win = 0; e.tgt = 0; e.attr = 0; e.addr = {32'h0, a}; e.tag = tag;
    for (int i = 7; i >= 0; i--) begin
      logic [15:0] sz;
      sz = sh_ctrl[i][31:16];
      if (sh_ctrl[i][0] && ((a[31:16] & ~sz) == (sh_base[i][31:16] & ~sz))) begin
        e.hit = 1; e.win = 3'(i);
        e.tgt = sh_ctrl[i][7:4]; e.attr = sh_ctrl[i][15:8];
        if (REMAP_WINS[i])
          e.addr = {sh_rhi[i], (sh_rlo[i][31:16] & ~sz) | (a[31:16] & sz), a[15:0]};
        else
          e.addr = {32'h0, a};
      end
    end
    return e;
  endfunction

  task automatic fail_line(input string msg);
    n_fail++;
    $display("FAIL %s", msg);
  endtask

  // one bus cycle: optional write, optional request (driven after a falling edge)
  task automatic step(input bit do_wr, input int win, input int sel,
      input logic [31:0] data, input bit do_req, input logic [31:0] a,
      input string tag);
    if (do_req) exp_q.push_back(predict(a, tag));
    cfg_wr_en = do_wr; cfg_wr_win = 3'(win); cfg_wr_sel = 2'(sel); cfg_wr_data = data;
    req_valid = do_req; req_addr = a;
    if (do_wr) begin
      case (sel)
        0: sh_ctrl[win] = data;
        1: sh_base[win] = data;
        2: sh_rlo[win]  = data;
        default: sh_rhi[win] = data;
      endcase
    end
    @(negedge clk);
    cfg_wr_en = 0; req_valid = 0;
  endtask

  task automatic wr(input int win, input int sel, input logic [31:0] data);
    step(1, win, sel, data, 0, 32'h0, "");
  endtask

  task automatic req(input logic [31:0] a, input string tag);
    step(0, 0, 0, 32'h0, 1, a, tag);
  endtask

  // monitor: compare responses against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t e;
      n_checks++;
      if (exp_q.size() == 0) begin
        fail_line("R8 unexpected response");
      end else begin
        e = exp_q.pop_front();
        if (rsp_hit !== e.hit || rsp_miss !== !e.hit || rsp_win !== e.win ||
            rsp_target !== e.tgt || rsp_attr !== e.attr || rsp_addr !== e.addr)
          fail_line($sformatf("%s actual hit=%0b miss=%0b win=%0d tgt=%h attr=%h addr=%h expected hit=%0b win=%0d tgt=%h attr=%h addr=%h",
            e.tag, rsp_hit, rsp_miss, rsp_win, rsp_target, rsp_attr, rsp_addr,
            e.hit, e.win, e.tgt, e.attr, e.addr));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    n_checks++;
    fail_line("watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      sh_ctrl[i] = 0; sh_base[i] = 0; sh_rlo[i] = 0; sh_rhi[i] = 0;
    end
    rst_n = 0; cfg_wr_en = 0; cfg_wr_win = 0; cfg_wr_sel = 0; cfg_wr_data = 0;
    req_valid = 0; req_addr = 0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_miss !== 0)
      fail_line($sformatf("R1 reset flags actual=%b%b%b expected=000", rsp_valid, rsp_hit, rsp_miss));
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: all disabled -> miss
    req(32'h1234_5678, "R1 miss after reset");

    // R10/R7: one-page window 2 without remap
    wr(2, 1, 32'h4000_0000);
    wr(2, 0, mk_ctrl(16'h0000, 8'h5A, 4'h3) | 32'h0000_000E); // R2 bits 3:1 ignored
    req(32'h4000_ABCD, "R10 R7 R2 one-page hit");
    req(32'h4001_0000, "R3 one page boundary miss");

    // R3: 16 MiB window 3
    wr(3, 1, 32'h5000_0000);
    wr(3, 0, mk_ctrl(16'h00FF, 8'h11, 4'h4));
    req(32'h50FF_FFFF, "R3 16MiB top hit");
    req(32'h5100_0000, "R3 16MiB boundary miss");
    req(32'h4FFF_FFFF, "R3 below base miss");

    // R3: low base bits ignored
    wr(4, 1, 32'h6000_FFFF);
    wr(4, 0, mk_ctrl(16'h0000, 8'h22, 4'h6));
    req(32'h6000_0000, "R3 base low bits ignored");

    // R4: overlapping window 5 (4 pages at 0x4000_0000)
    wr(5, 1, 32'h4000_0000);
    wr(5, 0, mk_ctrl(16'h0003, 8'h33, 4'h5));
    req(32'h4002_0000, "R4 only win5");
    req(32'h4000_0100, "R4 lowest index wins");

    // R5: remap window 0
    wr(0, 1, 32'h8000_0000);
    wr(0, 2, 32'h1230_0000);
    wr(0, 3, 32'h0000_0009);
    wr(0, 0, mk_ctrl(16'h000F, 8'hE8, 4'h1));
    req(32'h8007_4321, "R5 remap translate");

    // R6: identity remap window 1
    wr(1, 1, 32'h9000_0000);
    wr(1, 2, 32'h9000_0000);
    wr(1, 3, 32'h0000_0000);
    wr(1, 0, mk_ctrl(16'h00FF, 8'h44, 4'h2));
    req(32'h90AB_CDEF, "R6 identity remap");

    // R7: remap writes to window 2 ignored
    wr(2, 2, 32'hFFFF_0000);
    wr(2, 3, 32'h0000_0001);
    req(32'h4000_ABCD, "R7 remap writes ignored");

    // R4: higher window 7 overlaps remap window 0
    wr(7, 1, 32'h8000_0000);
    wr(7, 0, mk_ctrl(16'h0000, 8'h77, 4'h7));
    req(32'h8000_0000, "R4 win0 beats win7");

    // R9: clear window 2 in the same cycle as a request
    step(1, 2, 0, 32'h0, 1, 32'h4000_0100, "R9 old value same cycle");
    req(32'h4000_0100, "R9 R2 cleared window no hit");

    // R2: disable everything but check a cleared single window misses
    wr(5, 0, 32'h0);
    req(32'h4000_0100, "R2 cleared windows miss");

    // R8: idle cycle gives no valid
    @(negedge clk);
    n_checks++;
    if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_miss !== 0)
      fail_line($sformatf("R8 idle actual=%b%b%b expected=000", rsp_valid, rsp_hit, rsp_miss));

    // R8: back-to-back requests
    req(32'h8000_FFFF, "R8 back to back 1");
    req(32'h9012_0000, "R8 back to back 2");
    req(32'hC000_0000, "R8 back to back 3");
    repeat (3) @(negedge clk);

    n_checks++;
    if (exp_q.size() != 0)
      fail_line($sformatf("R8 pending responses actual=%0d expected=0", exp_q.size()));
    finish_run();
  end
endmodule